// File: doc/BRIEF.md
# Multi-Mode Memory Lookup Datapath

This block maps an input word onto an output word through a lookup table. The input word forms the table address, and the entry read back becomes the output word. The table is a separate storage block. The datapath drives its read address and receives its read data in the same cycle. The table contents are loaded through a host path that is not part of this block. Only the low `log2(DEPTH)` address bits are used, so the default 256-entry table is small enough to simulate.

A 2-bit mode input selects one of four behaviours:

- **Transparent:** a pure combinational lookup.
- **Strobe:** the address is captured when the AND of the enable inputs rises. The result is then held, and a group of identical ready lines rises a fixed number of cycles later.
- **Pulse:** works like strobe, but the true output bits fall after a set width. Each capture then gives exactly one pulse per bit, so downstream counters can count them.
- **Inhibit:** the front inputs are ignored and the table is addressed by the host address. This lets the host inspect the table it is programming.

The front interface is a level-and-edge interface, not a stream. The input word has no valid/ready pair and the block applies no back-pressure. A capture is taken on every qualifying enable edge, and the ready lines only report that the held word has settled.

Top module: `lut_datapath`

## Requirements
- R1: The table address is the low AW = log2(DEPTH) bits of the selected source word. With the default DEPTH of 256, that is bits [7:0]. The higher bits have no effect on the output word.
- R2: In mode 2'b00 (transparent), the table address follows `in_word_i` in the same cycle without any enable. `out_word_o` is the addressed entry and `ready_o` is all zeros.
- R3: In mode 2'b01 (strobe), the address is captured at a clock edge where the AND of all `en_i` bits is 1 and was 0 at the previous edge. Otherwise the address and output word hold.
- R4: A capture needs every `en_i` bit high. An enable input that is not used by the system is tied to 1 and then counts as true.
- R5: In strobe mode, all `ready_o` bits are 0 from the capture edge until READY_DLY (default 2) edges later. At that edge they all become 1 and stay 1 until the next capture. The output word is stable before ready rises.
- R6: In mode 2'b10 (pulse), `out_word_o` shows the captured entry for PULSE_W (default 3) cycles after a capture and is 0 afterwards. This gives exactly one pulse per capture.
- R7: In pulse mode, `ready_o` is high from READY_DLY edges after the capture until the pulse ends, and falls in the same cycle as the output bits.
- R8: In mode 2'b11 (inhibit), the table address comes from `host_addr_i`, `out_word_o` is that entry, and `ready_o` is 0. Neither `in_word_i` nor `en_i` causes a capture.
- R9: After a period in transparent or inhibit mode, `ready_o` stays 0 in strobe or pulse mode until a new capture. The previously captured address is still shown.
- R10: Reset clears the captured address to 0 and drives `ready_o` low. An enable AND held high through reset is treated as already high, so it does not capture when reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 transparent, 01 strobe, 10 pulse, 11 inhibit |
| in_word_i | input | IN_W (16) | Front input word |
| en_i | input | N_EN (4) | Enable inputs, ANDed together |
| host_addr_i | input | IN_W (16) | Host address used in inhibit mode |
| tbl_addr_o | output | AW (8) | Table read address |
| tbl_data_i | input | DW (16) | Table read data for `tbl_addr_o`, same cycle |
| out_word_o | output | DW (16) | Output word |
| ready_o | output | N_RDY (4) | Identical output-ready lines |

## Verification
In transparent and inhibit modes, the output word is due in the same cycle as its address source. The bench therefore drives inputs on the falling edge and reads the result before the next rising edge.

In the latched modes, the word changes after the capture edge itself. Ready is due exactly READY_DLY edges after the capture, and the pulse ends PULSE_W edges after the capture. The vector table advances one edge per row, so each row's expected word and ready level fall on the exact cycle these counts give.

The directed tests cover reset, release of reset with the enables already high, and a capture blocked by one low enable. They too sample on the falling edge after a known number of rising edges.

// File: rtl/lut_pkg.sv
package lut_pkg;

  typedef enum logic [1:0] {
    MODE_PASS  = 2'b00,
    MODE_LATCH = 2'b01,
    MODE_PULSE = 2'b10,
    MODE_HOST  = 2'b11
  } lut_mode_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/lut_enable_edge.sv
module lut_enable_edge #(
  parameter int unsigned N_EN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EN-1:0] en_i,
  output logic            all_o,
  output logic            edge_o
);

  logic all_q;

  assign all_o  = &en_i;
  assign edge_o = all_o & ~all_q;

  // Reset value 1: enables already high at release are not a fresh edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) all_q <= 1'b1;
    else        all_q <= all_o;
  end

endmodule

// File: rtl/lut_capture.sv
module lut_capture
  import lut_pkg::*;
#(
  parameter int unsigned AW      = 8,
  parameter int unsigned AGE_MAX = 3,
  parameter int unsigned CNT_W   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_i,
  input  logic             edge_i,
  input  logic [AW-1:0]    addr_i,
  output logic [AW-1:0]    addr_o,
  output logic [CNT_W-1:0] age_o,
  output logic             armed_o
);

  localparam logic [CNT_W-1:0] AGE_TOP = CNT_W'(AGE_MAX);

  logic latched_mode;
  logic take;

  assign latched_mode = (mode_i == MODE_LATCH) || (mode_i == MODE_PULSE);
  assign take         = latched_mode && edge_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_o  <= '0;
      age_o   <= AGE_TOP;
      armed_o <= 1'b0;
    end else begin
      if (take) begin
        addr_o  <= addr_i;
        age_o   <= '0;
        armed_o <= 1'b1;
      end else begin
        if (age_o != AGE_TOP) age_o <= age_o + 1'b1;
        if (!latched_mode) armed_o <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lut_out_shaper.sv
module lut_out_shaper
  import lut_pkg::*;
#(
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 16,
  parameter int unsigned N_RDY     = 4,
  parameter int unsigned READY_DLY = 2,
  parameter int unsigned PULSE_W   = 3,
  parameter int unsigned CNT_W     = 2
) (
  input  logic [1:0]       mode_i,
  input  logic [AW-1:0]    front_addr_i,
  input  logic [AW-1:0]    host_addr_i,
  input  logic [AW-1:0]    cap_addr_i,
  input  logic [CNT_W-1:0] age_i,
  input  logic             armed_i,
  input  logic [DW-1:0]    tbl_data_i,
  output logic [AW-1:0]    tbl_addr_o,
  output logic [DW-1:0]    word_o,
  output logic [N_RDY-1:0] ready_o
);

  localparam logic [CNT_W-1:0] RDY_AT = CNT_W'(READY_DLY);
  localparam logic [CNT_W-1:0] PW_END = CNT_W'(PULSE_W);

  logic rdy;
  logic settled;
  logic in_pulse;

  assign settled  = armed_i && (age_i >= RDY_AT);
  assign in_pulse = armed_i && (age_i < PW_END);

  always_comb begin
    tbl_addr_o = cap_addr_i;
    word_o     = tbl_data_i;
    rdy        = 1'b0;
    unique case (mode_i)
      MODE_PASS: begin
        tbl_addr_o = front_addr_i;
      end
      MODE_LATCH: begin
        rdy = settled;
      end
      MODE_PULSE: begin
        word_o = in_pulse ? tbl_data_i : '0;
        rdy    = settled && in_pulse;
      end
      default: begin
        tbl_addr_o = host_addr_i;
      end
    endcase
  end

  for (genvar g = 0; g < N_RDY; g++) begin : g_rdy
    assign ready_o[g] = rdy;
  end

endmodule

// File: rtl/lut_datapath.sv
module lut_datapath
  import lut_pkg::*;
#(
  parameter int unsigned IN_W      = 16,
  parameter int unsigned DW        = 16,
  parameter int unsigned DEPTH     = 256,
  parameter int unsigned N_EN      = 4,
  parameter int unsigned N_RDY     = 4,
  parameter int unsigned READY_DLY = 2,
  parameter int unsigned PULSE_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [1:0]                 mode_i,
  input  logic [IN_W-1:0]            in_word_i,
  input  logic [N_EN-1:0]            en_i,
  input  logic [IN_W-1:0]            host_addr_i,
  output logic [$clog2(DEPTH)-1:0]   tbl_addr_o,
  input  logic [DW-1:0]              tbl_data_i,
  output logic [DW-1:0]              out_word_o,
  output logic [N_RDY-1:0]           ready_o
);

  localparam int unsigned AW      = $clog2(DEPTH);
  localparam int unsigned AGE_MAX = max_u(READY_DLY, PULSE_W);
  localparam int unsigned CNT_W   = $clog2(AGE_MAX + 1);

  logic             en_all;
  logic             en_edge;
  logic [AW-1:0]    cap_addr;
  logic [CNT_W-1:0] age;
  logic             armed;

  if (AW < IN_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^{in_word_i[IN_W-1:AW], host_addr_i[IN_W-1:AW], en_all};
  end else begin : g_nohi
    logic unused_all;
    assign unused_all = en_all;
  end

  lut_enable_edge #(.N_EN(N_EN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_i   (en_i),
    .all_o  (en_all),
    .edge_o (en_edge)
  );

  lut_capture #(.AW(AW), .AGE_MAX(AGE_MAX), .CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_i  (mode_i),
    .edge_i  (en_edge),
    .addr_i  (in_word_i[AW-1:0]),
    .addr_o  (cap_addr),
    .age_o   (age),
    .armed_o (armed)
  );

  lut_out_shaper #(
    .AW(AW), .DW(DW), .N_RDY(N_RDY),
    .READY_DLY(READY_DLY), .PULSE_W(PULSE_W), .CNT_W(CNT_W)
  ) u_shape (
    .mode_i       (mode_i),
    .front_addr_i (in_word_i[AW-1:0]),
    .host_addr_i  (host_addr_i[AW-1:0]),
    .cap_addr_i   (cap_addr),
    .age_i        (age),
    .armed_i      (armed),
    .tbl_data_i   (tbl_data_i),
    .tbl_addr_o   (tbl_addr_o),
    .word_o       (out_word_o),
    .ready_o      (ready_o)
  );

endmodule

// File: rtl/lut_datapath_chk.sv
module lut_datapath_chk
  import lut_pkg::*;
#(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 8,
  parameter int unsigned N_RDY = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_i,
  input logic [IN_W-1:0]  in_word_i,
  input logic [IN_W-1:0]  host_addr_i,
  input logic [AW-1:0]    tbl_addr_o,
  input logic [DW-1:0]    out_word_o,
  input logic [N_RDY-1:0] ready_o,
  input logic             edge_i
);

  assert_trans_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PASS) |-> (tbl_addr_o == in_word_i[AW-1:0] && ready_o == '0));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_LATCH && !edge_i) |=> (mode_i != MODE_LATCH || $stable(tbl_addr_o)));

  assert_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready_o[0]) && $stable(mode_i)) |-> $stable(out_word_o));

  assert_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_PULSE && $past(mode_i) == MODE_PULSE && $fell(ready_o[0]) && !$past(edge_i))
      |-> (out_word_o == '0));

  assert_inhibit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_HOST) |-> (tbl_addr_o == host_addr_i[AW-1:0] && ready_o == '0));

endmodule

bind lut_datapath lut_datapath_chk #(
  .IN_W(IN_W), .DW(DW), .AW(AW), .N_RDY(N_RDY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_i      (mode_i),
  .in_word_i   (in_word_i),
  .host_addr_i (host_addr_i),
  .tbl_addr_o  (tbl_addr_o),
  .out_word_o  (out_word_o),
  .ready_o     (ready_o),
  .edge_i      (en_edge)
);

// File: tb/sim_lut_datapath.sv
module sim_lut_datapath;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] in_word = '0;
  logic [3:0]  en = '0;
  logic [15:0] host = '0;
  logic [7:0]  tbl_addr;
  logic [15:0] tbl_data;
  logic [15:0] out_word;
  logic [3:0]  ready;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  function automatic logic [15:0] lut_f(input logic [7:0] a);
    return {a ^ 8'h3C, ~a};
  endfunction

  assign tbl_data = lut_f(tbl_addr);

  lut_datapath u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .in_word_i(in_word), .en_i(en),
    .host_addr_i(host), .tbl_addr_o(tbl_addr), .tbl_data_i(tbl_data),
    .out_word_o(out_word), .ready_o(ready)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic [15:0] in;
    logic [3:0]  en;
    logic [15:0] host;
    logic [7:0]  ea;    // expected table address
    logic        ez;    // expected word forced to zero
    logic        er;    // expected ready level
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 16'h0012, 4'h0, 16'h0000, 8'h12, 1'b0, 1'b0}, // 0 R2
    '{2'b00, 16'h1234, 4'h0, 16'h0000, 8'h34, 1'b0, 1'b0}, // 1 R1
    '{2'b01, 16'h0055, 4'h0, 16'h0000, 8'h00, 1'b0, 1'b0}, // 2 R3 no edge
    '{2'b01, 16'h0055, 4'hF, 16'h0000, 8'h55, 1'b0, 1'b0}, // 3 R3 capture
    '{2'b01, 16'h0077, 4'hF, 16'h0000, 8'h55, 1'b0, 1'b0}, // 4 R5 age1
    '{2'b01, 16'h0077, 4'hF, 16'h0000, 8'h55, 1'b0, 1'b1}, // 5 R5 ready
    '{2'b01, 16'h0099, 4'hB, 16'h0000, 8'h55, 1'b0, 1'b1}, // 6 R4 hold
    '{2'b01, 16'h0099, 4'hF, 16'h0000, 8'h99, 1'b0, 1'b0}, // 7 R3 recapture
    '{2'b01, 16'h00AA, 4'h7, 16'h0000, 8'h99, 1'b0, 1'b0}, // 8 R5
    '{2'b01, 16'h00AA, 4'h7, 16'h0000, 8'h99, 1'b0, 1'b1}, // 9 R5
    '{2'b10, 16'h0021, 4'h0, 16'h0000, 8'h00, 1'b1, 1'b0}, // 10 R6 idle
    '{2'b10, 16'h0021, 4'hF, 16'h0000, 8'h21, 1'b0, 1'b0}, // 11 R6 start
    '{2'b10, 16'h0044, 4'hF, 16'h0000, 8'h21, 1'b0, 1'b0}, // 12 R6
    '{2'b10, 16'h0044, 4'hF, 16'h0000, 8'h21, 1'b0, 1'b1}, // 13 R7
    '{2'b10, 16'h0044, 4'hF, 16'h0000, 8'h00, 1'b1, 1'b0}, // 14 R7 end
    '{2'b10, 16'h0044, 4'hF, 16'h0000, 8'h00, 1'b1, 1'b0}, // 15 R6 single
    '{2'b11, 16'h0066, 4'h0, 16'h0130, 8'h30, 1'b0, 1'b0}, // 16 R8
    '{2'b11, 16'h0066, 4'hF, 16'h0130, 8'h30, 1'b0, 1'b0}, // 17 R8 edge ignored
    '{2'b11, 16'h0066, 4'hF, 16'h0007, 8'h07, 1'b0, 1'b0}, // 18 R8
    '{2'b01, 16'h0088, 4'hF, 16'h0007, 8'h21, 1'b0, 1'b0}  // 19 R9
  };

  task automatic chk_word(input string req, input logic [15:0] exp);
    n_vec++;
    if (out_word !== exp) begin
      n_bad++;
      $display("FAIL %s word: actual %h expected %h", req, out_word, exp);
    end
  endtask

  task automatic chk_rdy(input string req, input logic exp);
    n_vec++;
    if (ready !== {4{exp}}) begin
      n_bad++;
      $display("FAIL %s ready: actual %b expected %b", req, ready, {4{exp}});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      mode = VEC[i].mode; in_word = VEC[i].in; en = VEC[i].en; host = VEC[i].host;
      @(negedge clk);
      chk_word($sformatf("row%0d", i), VEC[i].ez ? 16'h0000 : lut_f(VEC[i].ea));
      chk_rdy($sformatf("row%0d", i), VEC[i].er);
    end

    // R10: reset state, enables held high through reset
    mode = 2'b01; en = 4'hF; in_word = 16'h0033; rst_n = 1'b0;
    @(negedge clk);
    chk_word("R10 reset", lut_f(8'h00));
    chk_rdy("R10 reset", 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_word("R10 no capture at release", lut_f(8'h00));
    en = 4'h0;
    @(negedge clk);
    en = 4'hF;
    @(negedge clk);
    chk_word("R3 capture after reset", lut_f(8'h33));
    chk_rdy("R5 low at capture", 1'b0);
    repeat (2) @(negedge clk);
    chk_rdy("R5 high after delay", 1'b1);

    // R4: one enable low blocks the capture
    in_word = 16'h0044; en = 4'h0;
    @(negedge clk);
    en = 4'hE;
    @(negedge clk);
    chk_word("R4 partial enable", lut_f(8'h33));
    en = 4'hF;
    @(negedge clk);
    chk_word("R4 full enable", lut_f(8'h44));

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule